// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects single-cycle event pulses from a parameterised set of peripheral sources (16 by default) and tells a processor core when to branch, to which of two fixed vector addresses, and at which urgency level. Each source owns a sticky pending flag, an enable bit and a level-select bit. A mode bit picks between a two-level scheme and a flat scheme where every source is urgent. Two global gates, one per level, sit in a byte-wide register file that software reaches through a plain write strobe, an address and a combinational read-data path. The port has no back-pressure: every write strobe is accepted in its cycle and read data is valid in the same cycle as the address.

The core answers a request with an acknowledge strobe when it takes the vector. It signals the end of a handler with a return strobe. The controller tracks nesting in a two-entry level stack. An urgent request may interrupt a normal handler, but a normal request never interrupts an urgent one. Register map: address 0 holds the mode bit; address 1 holds the two gates; addresses 2-3, 4-5 and 6-7 hold the flag, enable and level-select bytes for sources 0-7 and 8-15.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: An `evt_i` bit pulsed for one cycle sets the matching flag (address 2 bits 0-7 hold sources 0-7, address 3 holds sources 8-15). A write to a flag byte loads it. When an event and a write that clears the same bit land in one cycle, the flag ends up set.
- R2: A source whose enable bit (address 4/5, same bit layout) is 0 never raises `irq_req_o`, but its flag is still set and can be read.
- R3: With the mode bit (address 0 bit 7) at 1, a source requests when its flag and enable are set and the gate of its level is set (address 1 bit 7 for urgent, bit 6 for normal). A level-select bit of 1 (address 6/7) gives `irq_vec_o` = 0x0008 and `irq_lvl_hi_o` = 1. A 0 gives 0x0018 and `irq_lvl_hi_o` = 0.
- R4: When urgent and normal sources are pending together, the urgent vector 0x0008 is presented.
- R5: With the mode bit at 0, every request is urgent (0x0008, `irq_lvl_hi_o` = 1) and needs address 1 bit 7. Sources below index CORE_SRC (3) ignore bit 6. Higher sources also need bit 6.
- R6: An acknowledge while `irq_req_o` is high clears the gate of the presented level, which reads back as 0, and pushes that level. `svc_lvl_o` then shows it (0 idle, 1 normal, 2 urgent). An acknowledge with no request has no effect. A return strobe that arrives with an accepted acknowledge is ignored.
- R7: While a normal handler runs, a pending urgent source raises `irq_req_o` with vector 0x0008.
- R8: While an urgent handler runs, no normal request is raised, even if software sets the normal gate.
- R9: A return strobe pops the top level and sets that level's gate again. `svc_lvl_o` falls back to the level below, or to idle.
- R10: With several sources of one level pending, `irq_req_o` stays high with a steady vector until the acknowledge. It then drops.
- R11: After reset every register reads 0, `irq_req_o` is 0 and `svc_lvl_o` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Vector address for the presented request |
| irq_lvl_hi_o | output | 1 | Presented request is urgent |
| irq_ack_i | input | 1 | Core has taken the vector |
| irq_ret_i | input | 1 | Core has left a handler |
| svc_lvl_o | output | 2 | Level now in service: 0 idle, 1 normal, 2 urgent |

## Verification
The bench targets the event-against-clear collision; a design that lets the write win loses an event for good. It nests an urgent handler inside a normal one, then tries to start a normal request inside the urgent handler. A design without the level mask would preempt the urgent handler, and one without preemption would stall urgent work. Two returns in a row must restore the gates in reverse order; a stack that pops the wrong entry re-arms the wrong level. The flat mode and the acknowledge with nothing pending are also covered, because a wrong peripheral gate or a stray push would leave `svc_lvl_o` stuck.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE = 2'd0,
    SVC_LOW  = 2'd1,
    SVC_HIGH = 2'd2
  } svc_lvl_e;

  localparam int          VEC_W    = 16;
  localparam logic [15:0] VEC_HI   = 16'h0008;
  localparam logic [15:0] VEC_LO   = 16'h0018;
  localparam int          MODE_ADR = 0;
  localparam int          GATE_ADR = 1;
  localparam int          FLG_BASE = 2;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_h_i,
  input  logic               clr_l_i,
  input  logic               set_h_i,
  input  logic               set_l_i,
  output logic               prio_mode_o,
  output logic               gate_h_o,
  output logic               gate_l_o,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] enables_o,
  output logic [NUM_SRC-1:0] levels_o
);
  import irq_pkg::*;
  localparam int NB      = NUM_SRC / 8;
  localparam int EN_BASE = FLG_BASE + NB;
  localparam int PR_BASE = EN_BASE + NB;

  logic [NUM_SRC-1:0] flags_n, en_n, pr_n;
  logic               mode_n, h_n, l_n;

  always_comb begin
    flags_n = flags_o;
    en_n    = enables_o;
    pr_n    = levels_o;
    mode_n  = prio_mode_o;
    h_n     = gate_h_o;
    l_n     = gate_l_o;
    if (wr_i) begin
      if (addr_i == ADDR_W'(MODE_ADR)) mode_n = wdata_i[7];
      if (addr_i == ADDR_W'(GATE_ADR)) begin
        h_n = wdata_i[7];
        l_n = wdata_i[6];
      end
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(FLG_BASE + b)) flags_n[8*b +: 8] = wdata_i;
        if (addr_i == ADDR_W'(EN_BASE + b))  en_n[8*b +: 8]    = wdata_i;
        if (addr_i == ADDR_W'(PR_BASE + b))  pr_n[8*b +: 8]    = wdata_i;
      end
    end
    flags_n = flags_n | evt_i;
    if (clr_h_i) h_n = 1'b0;
    if (clr_l_i) l_n = 1'b0;
    if (set_h_i) h_n = 1'b1;
    if (set_l_i) l_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o     <= '0;
      enables_o   <= '0;
      levels_o    <= '0;
      prio_mode_o <= 1'b0;
      gate_h_o    <= 1'b0;
      gate_l_o    <= 1'b0;
    end else begin
      flags_o     <= flags_n;
      enables_o   <= en_n;
      levels_o    <= pr_n;
      prio_mode_o <= mode_n;
      gate_h_o    <= h_n;
      gate_l_o    <= l_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(MODE_ADR)) rdata_o = {prio_mode_o, 7'b0};
    if (addr_i == ADDR_W'(GATE_ADR)) rdata_o = {gate_h_o, gate_l_o, 6'b0};
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_W'(FLG_BASE + b)) rdata_o = flags_o[8*b +: 8];
      if (addr_i == ADDR_W'(EN_BASE + b))  rdata_o = enables_o[8*b +: 8];
      if (addr_i == ADDR_W'(PR_BASE + b))  rdata_o = levels_o[8*b +: 8];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC  = 16,
  parameter int CORE_SRC = 3
) (
  input  logic                      prio_mode_i,
  input  logic                      gate_h_i,
  input  logic                      gate_l_i,
  input  logic                      hi_busy_i,
  input  logic [NUM_SRC-1:0]        flags_i,
  input  logic [NUM_SRC-1:0]        enables_i,
  input  logic [NUM_SRC-1:0]        levels_i,
  output logic                      req_o,
  output logic                      lvl_hi_o,
  output logic [irq_pkg::VEC_W-1:0] vec_o
);
  import irq_pkg::*;
  logic [NUM_SRC-1:0] core_mask, armed, flat_sel;
  logic               hi_any, lo_any;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_core
    assign core_mask[i] = (i < CORE_SRC);
  end

  assign armed    = flags_i & enables_i;
  assign flat_sel = gate_l_i ? {NUM_SRC{1'b1}} : core_mask;

  always_comb begin
    if (prio_mode_i) begin
      hi_any = gate_h_i && |(armed & levels_i);
      lo_any = gate_l_i && !hi_busy_i && |(armed & ~levels_i);
    end else begin
      hi_any = gate_h_i && |(armed & flat_sel);
      lo_any = 1'b0;
    end
  end

  assign req_o    = hi_any | lo_any;
  assign lvl_hi_o = hi_any;
  assign vec_o    = hi_any ? VEC_HI : VEC_LO;
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     take_i,
  input  logic                     take_hi_i,
  input  logic                     ret_i,
  output logic                     clr_h_o,
  output logic                     clr_l_o,
  output logic                     set_h_o,
  output logic                     set_l_o,
  output logic                     hi_busy_o,
  output irq_pkg::svc_lvl_e        svc_lvl_o
);
  import irq_pkg::*;
  logic [1:0] cnt_q;
  logic [1:0] ent_q;
  logic       top_hi, pop;

  always_comb begin
    case (cnt_q)
      2'd1:    top_hi = ent_q[0];
      2'd2:    top_hi = ent_q[1];
      default: top_hi = 1'b0;
    endcase
  end

  assign pop       = ret_i && !take_i && (cnt_q != 2'd0);
  assign clr_h_o   = take_i && take_hi_i;
  assign clr_l_o   = take_i && !take_hi_i;
  assign set_h_o   = pop && top_hi;
  assign set_l_o   = pop && !top_hi;
  assign hi_busy_o = top_hi;
  assign svc_lvl_o = (cnt_q == 2'd0) ? SVC_IDLE : (top_hi ? SVC_HIGH : SVC_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= 2'd0;
      ent_q <= 2'b00;
    end else if (take_i && cnt_q != 2'd2) begin
      ent_q[cnt_q[0]] <= take_hi_i;
      cnt_q           <= cnt_q + 2'd1;
    end else if (pop) begin
      cnt_q <= cnt_q - 2'd1;
    end
  end
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl #(
  parameter int NUM_SRC  = 16,
  parameter int CORE_SRC = 3,
  parameter int ADDR_W   = $clog2(2 + 3 * (NUM_SRC / 8))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               irq_req_o,
  output logic [15:0]        irq_vec_o,
  output logic               irq_lvl_hi_o,
  input  logic               irq_ack_i,
  input  logic               irq_ret_i,
  output logic [1:0]         svc_lvl_o
);
  import irq_pkg::*;
  logic [NUM_SRC-1:0] flags_q, enables_q, levels_q;
  logic               prio_mode_q, gate_h_q, gate_l_q;
  logic               clr_h, clr_l, set_h, set_l, hi_busy, take;
  svc_lvl_e           svc_lvl;

  assign take      = irq_ack_i && irq_req_o;
  assign svc_lvl_o = svc_lvl;

  irq_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .evt_i, .clr_h_i(clr_h), .clr_l_i(clr_l), .set_h_i(set_h), .set_l_i(set_l),
    .prio_mode_o(prio_mode_q), .gate_h_o(gate_h_q), .gate_l_o(gate_l_q),
    .flags_o(flags_q), .enables_o(enables_q), .levels_o(levels_q)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .CORE_SRC(CORE_SRC)) arb_i (
    .prio_mode_i(prio_mode_q), .gate_h_i(gate_h_q), .gate_l_i(gate_l_q),
    .hi_busy_i(hi_busy), .flags_i(flags_q), .enables_i(enables_q), .levels_i(levels_q),
    .req_o(irq_req_o), .lvl_hi_o(irq_lvl_hi_o), .vec_o(irq_vec_o)
  );

  irq_level_stack stk_i (
    .clk_i, .rst_ni,
    .take_i(take), .take_hi_i(irq_lvl_hi_o), .ret_i(irq_ret_i),
    .clr_h_o(clr_h), .clr_l_o(clr_l), .set_h_o(set_h), .set_l_o(set_l),
    .hi_busy_o(hi_busy), .svc_lvl_o(svc_lvl)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_req_o,
  input logic [15:0]        irq_vec_o,
  input logic               irq_lvl_hi_o,
  input logic               irq_ack_i,
  input logic               irq_ret_i,
  input logic [1:0]         svc_lvl_o,
  input logic [NUM_SRC-1:0] flags_q,
  input logic [NUM_SRC-1:0] enables_q,
  input logic               prio_mode_q,
  input logic               gate_h_q,
  input logic               gate_l_q
);
  p_evt_sets_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  p_req_needs_armed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> |(flags_q & enables_q));

  p_flat_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !prio_mode_q) |-> (irq_vec_o == 16'h0008 && irq_lvl_hi_o));

  p_ack_clears_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && irq_lvl_hi_o) |=> !gate_h_q);

  p_ack_clears_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !irq_lvl_hi_o) |=> !gate_l_q);

  p_no_low_over_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_lvl_o == 2'd2) |-> !(irq_req_o && !irq_lvl_hi_o));

  p_ret_restores_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_ack_i && svc_lvl_o == 2'd2) |=> gate_h_q);
endmodule

bind irq_two_level_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
  .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .irq_lvl_hi_o(irq_lvl_hi_o),
  .irq_ack_i(irq_ack_i), .irq_ret_i(irq_ret_i), .svc_lvl_o(svc_lvl_o),
  .flags_q(flags_q), .enables_q(enables_q), .prio_mode_q(prio_mode_q),
  .gate_h_q(gate_h_q), .gate_l_q(gate_l_q)
);

// File: tb/irq_two_level_ctrl_tb.sv
module irq_two_level_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        irq_req_o;
  logic [15:0] irq_vec_o;
  logic        irq_lvl_hi_o;
  logic        irq_ack_i = 1'b0;
  logic        irq_ret_i = 1'b0;
  logic [1:0]  svc_lvl_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  irq_two_level_ctrl dut_i (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    reg_wr_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = 8'(d);
    tick();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr_i = 3'(a);
    #1;
    check(tag, int'(reg_rdata_o), exp);
  endtask

  task automatic pulse(input int e);
    evt_i = 16'(e); tick(); evt_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
  endtask

  task automatic ret();
    irq_ret_i = 1'b1; tick(); irq_ret_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd(a, 0, "R11 register after reset");
    check("R11 req after reset", int'(irq_req_o), 0);
    check("R11 svc after reset", int'(svc_lvl_o), 0);
  endtask

  task automatic t_flags();
    pulse(16'h0008);
    rd(2, 8'h08, "R1 flag set by event");
    reg_wr_i = 1'b1; reg_addr_i = 3'd2; reg_wdata_i = 8'h00; evt_i = 16'h0008;
    tick();
    reg_wr_i = 1'b0; evt_i = '0;
    rd(2, 8'h08, "R1 event wins over clear");
    wr(2, 0);
    rd(2, 0, "R1 write clears flag");
    pulse(16'h0200);
    rd(3, 8'h02, "R1 upper byte flag");
    wr(3, 0);
    check("R2 no request without enable", int'(irq_req_o), 0);
  endtask

  task automatic t_prio_vectors();
    wr(0, 8'h80); wr(1, 8'hC0); wr(4, 8'h04); wr(6, 8'h04);
    pulse(16'h0004);
    check("R3 high request", int'(irq_req_o), 1);
    check("R3 high vector", int'(irq_vec_o), 16'h0008);
    check("R3 high level", int'(irq_lvl_hi_o), 1);
    wr(2, 0);
    check("R3 req drops with flag", int'(irq_req_o), 0);
    wr(6, 0);
    pulse(16'h0004);
    check("R3 low vector", int'(irq_vec_o), 16'h0018);
    check("R3 low level", int'(irq_lvl_hi_o), 0);
    wr(2, 0);
  endtask

  task automatic t_enable();
    pulse(16'h0020);
    check("R2 disabled source no request", int'(irq_req_o), 0);
    rd(2, 8'h20, "R2 disabled flag still set");
    wr(2, 0);
  endtask

  task automatic t_both();
    wr(4, 8'h14); wr(6, 8'h04);
    pulse(16'h0014);
    check("R4 high wins vector", int'(irq_vec_o), 16'h0008);
    check("R4 high wins level", int'(irq_lvl_hi_o), 1);
    wr(2, 0);
  endtask

  task automatic t_nest();
    pulse(16'h0010);
    check("R3 low pending", int'(irq_vec_o), 16'h0018);
    ack();
    rd(1, 8'h80, "R6 low gate cleared");
    check("R6 svc low", int'(svc_lvl_o), 1);
    check("R6 req drops after ack", int'(irq_req_o), 0);
    wr(2, 0);
    pulse(16'h0004);
    check("R7 high preempts low", int'(irq_req_o), 1);
    check("R7 preempt vector", int'(irq_vec_o), 16'h0008);
    ack();
    rd(1, 8'h00, "R6 high gate cleared");
    check("R6 svc high", int'(svc_lvl_o), 2);
    wr(1, 8'h40);
    pulse(16'h0010);
    check("R8 low blocked in high service", int'(irq_req_o), 0);
    wr(2, 0); wr(1, 8'h00);
    ret();
    rd(1, 8'h80, "R9 high gate restored");
    check("R9 back to low service", int'(svc_lvl_o), 1);
    ret();
    rd(1, 8'hC0, "R9 low gate restored");
    check("R9 back to idle", int'(svc_lvl_o), 0);
    ack();
    check("R6 ack without request ignored", int'(svc_lvl_o), 0);
  endtask

  task automatic t_single();
    wr(4, 8'h34);
    pulse(16'h0030);
    for (int k = 0; k < 3; k++) begin
      check("R10 request held", int'(irq_req_o), 1);
      check("R10 vector steady", int'(irq_vec_o), 16'h0018);
      tick();
    end
    ack();
    check("R10 request drops after ack", int'(irq_req_o), 0);
    ret();
    check("R9 idle after return", int'(svc_lvl_o), 0);
    wr(2, 0);
  endtask

  task automatic t_flat();
    wr(0, 0); wr(1, 8'h80); wr(4, 8'h02); wr(5, 8'h04);
    pulse(16'h0400);
    check("R5 peripheral gated by bit 6", int'(irq_req_o), 0);
    pulse(16'h0002);
    check("R5 core source requests", int'(irq_req_o), 1);
    check("R5 flat vector", int'(irq_vec_o), 16'h0008);
    check("R5 flat level", int'(irq_lvl_hi_o), 1);
    wr(2, 0);
    check("R5 still gated", int'(irq_req_o), 0);
    wr(1, 8'hC0);
    check("R5 peripheral after bit 6", int'(irq_req_o), 1);
    check("R5 peripheral vector", int'(irq_vec_o), 16'h0008);
    ack();
    check("R6 flat ack svc high", int'(svc_lvl_o), 2);
    rd(1, 8'h40, "R6 flat ack clears bit 7");
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_flags();
    t_prio_vectors();
    t_enable();
    t_both();
    t_nest();
    t_single();
    t_flat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule